// File: doc/BRIEF.md
# Two-Wire Serial Programming Host Sequencer

This block is the host end of a two-wire, low-pin-count link used to write and verify the program memory of a small target device. It runs from the system clock and produces the link clock and the bidirectional data line from it. Link timing is derived from the system clock frequency and from the minimum setup, inter-command and post-write delays, all set by parameters and rounded up to whole cycles.

Requests arrive through a valid/ready handshake. Six request codes map one-to-one onto the target's primitive commands: load, read, address increment, begin write, end write and bulk erase. The seventh code runs a complete program-and-verify pass for one word. That pass loads the word, writes it, reads it back, compares the low 12 bits, and then steps the address. The host keeps its own copy of the target address. Entering the mode puts that address at the top of the space (all ones), so the first program-and-verify pass starts with an extra increment that wraps the address to zero. A verify mismatch stops the sequencer, raises a sticky error flag and keeps the failing address.

Every data bit is placed on the line at a rising link-clock edge and held through the following falling edge, on which the target latches it. In read transfers the host releases the line and samples each bit late in the high phase.

Top module: `prog_link_host`

## Requirements
- R1: Each command is sent as exactly 6 link-clock pulses, LSb first, with the bit latched by the target on the falling edge. The command codes are load 0x02, read 0x04, increment 0x06, begin write 0x08, end write 0x0E and bulk erase 0x09. The request codes on reqOp are 0 load, 1 read, 2 increment, 3 begin write, 4 end write and 5 bulk erase; 6 and 7 both mean program-and-verify one word.
- R2: While the host drives the data line, the line changes only together with a rising link-clock edge. Each bit is set up at least SETUP_NS before and held at least SETUP_NS after every falling edge.
- R3: Load and read commands are followed by a 16-pulse data transfer made of a start cycle, 14 field bits LSb first, and a stop cycle. For a load, the host sends 0 in the start and stop cycles, reqWord in field bits 0..11, and 0 in field bits 12..13.
- R4: For the whole of a read transfer progDatOe is low, and it is high for the whole of a load transfer. The host samples each bit during the high phase. rspWord carries field bits 0..11 of the read transfer, with field bits 12..13 ignored.
- R5: At least SHORT_US microseconds pass between the last falling edge of a load or read command and the first rising edge of its data transfer.
- R6: At least SHORT_US microseconds pass between the last falling edge of one transaction and the first rising edge of the next command. After end write the minimum is LONG_US microseconds.
- R7: reqReady is high only while the block is idle, and a request is taken on a cycle with reqValid and reqReady both high. On completion, once the closing delay has run out, rspValid rises for exactly one cycle.
- R8: The tracked address is all ones (0x7FF) after reset and steps by one, wrapping, on every increment command. A program-and-verify pass issues load, begin write, end write, read and increment, in that order. When the tracked address is 0x7FF, the pass issues one increment before the load.
- R9: A verify mismatch in field bits 0..11 has the following effects: verifyErr goes high and stays high until reset, errAddr holds the tracked address of the failing word, no increment is issued, no further command is sent, and reqReady stays low.
- R10: After reset, progClk is low, verifyErr is low, and both reqReady and modeEn are high from the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 3 | Request code (see R1) |
| reqWord | input | 12 | Word for load and program-and-verify |
| reqReady | output | 1 | Block idle and able to take a request |
| rspValid | output | 1 | One-cycle completion pulse |
| rspWord | output | 12 | Word returned by the latest read |
| verifyErr | output | 1 | Sticky verify mismatch flag |
| errAddr | output | 11 | Address of the word that failed verify |
| modeEn | output | 1 | Enable for the external programming-voltage switch |
| progClk | output | 1 | Link clock to the target |
| progDat | output | 1 | Data driven toward the target |
| progDatOe | output | 1 | Output enable for progDat |
| progDatIn | input | 1 | Data line as seen from the target side |

## Verification
Some properties are checked by assertions on every cycle. The data line is held across each falling link-clock edge and changes only on a rising one. The clock stays low while idle or waiting. rspValid lasts one cycle. The tracked address moves only by one. Once a verify error is seen, the error flag, the stored address and the quiet link stay as they are. Other behaviour can only be shown by the bench's target model and its timestamps, which watch the wires directly: the command codes and their order, the padded load field, the 1 µs and 100 µs gaps in nanoseconds, the extra increment at mode entry, the masking of the two top read bits, and the halt on a corrupted write.

// File: rtl/prog_host_pkg.sv
`timescale 1ns/1ps
package prog_host_pkg;
  localparam int WORD_W  = 12;
  localparam int FIELD_W = 14;
  localparam int ADDR_W  = 11;
  localparam int CMD_W   = 6;
  localparam int XFER_W  = FIELD_W + 2;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_READ  = 3'd1,
    OP_INC   = 3'd2,
    OP_BEGIN = 3'd3,
    OP_END   = 3'd4,
    OP_ERASE = 3'd5,
    OP_PROG  = 3'd6
  } opE;

  // control -> datapath strobes
  typedef struct packed {
    logic              goShift;
    logic              goWait;
    logic              longWait;
    logic              drive;
    logic              dataPhase;
    logic [XFER_W-1:0] pattern;
  } strobeT;

  function automatic logic [CMD_W-1:0] cmdOf(opE op);
    case (op)
      OP_LOAD:  cmdOf = 6'h02;
      OP_READ:  cmdOf = 6'h04;
      OP_INC:   cmdOf = 6'h06;
      OP_BEGIN: cmdOf = 6'h08;
      OP_END:   cmdOf = 6'h0E;
      OP_ERASE: cmdOf = 6'h09;
      default:  cmdOf = 6'h00;
    endcase
  endfunction
endpackage

// File: rtl/prog_host_dp.sv
`timescale 1ns/1ps
module prog_host_dp
  import prog_host_pkg::*;
#(
  parameter int HALF_CYC  = 20,
  parameter int SHORT_CYC = 200,
  parameter int LONG_CYC  = 20000
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic               datIn,
  output logic               done,
  output logic [WORD_W-1:0]  rxWord,
  output logic               pClk,
  output logic               pDat,
  output logic               pOe
);
  localparam int TW = $clog2(LONG_CYC + 1);
  localparam logic [TW-1:0] HALF_L  = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] SHORT_L = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] LONG_L  = TW'(LONG_CYC - 1);

  typedef enum logic [1:0] {D_IDLE, D_HIGH, D_LOW, D_WAIT} dstE;

  dstE               st;
  logic [TW-1:0]     tmr;
  logic [4:0]        left;
  logic [XFER_W-2:0] sh;
  logic [XFER_W-2:0] rx;

  assign rxWord = rx[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= D_IDLE; tmr <= '0; left <= '0; sh <= '0; rx <= '0;
      done <= 1'b0; pClk <= 1'b0; pDat <= 1'b0; pOe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        D_IDLE: begin
          if (stb.goShift) begin
            st   <= D_HIGH;
            tmr  <= HALF_L;
            left <= stb.dataPhase ? 5'd16 : 5'(CMD_W);
            sh   <= stb.pattern[XFER_W-1:1];
            pOe  <= stb.drive;
            pClk <= 1'b1;
            if (stb.drive) pDat <= stb.pattern[0];
          end else if (stb.goWait) begin
            st  <= D_WAIT;
            tmr <= stb.longWait ? LONG_L : SHORT_L;
          end
        end
        D_HIGH: begin
          if (tmr == '0) begin
            rx   <= {datIn, rx[XFER_W-2:1]};   // sample late in high phase
            pClk <= 1'b0;
            st   <= D_LOW;
            tmr  <= HALF_L;
          end else tmr <= tmr - 1'b1;
        end
        D_LOW: begin
          if (tmr == '0) begin
            if (left == 5'd1) begin
              st   <= D_IDLE;
              done <= 1'b1;
            end else begin
              left <= left - 1'b1;
              sh   <= {1'b0, sh[XFER_W-2:1]};
              if (pOe) pDat <= sh[0];
              pClk <= 1'b1;
              st   <= D_HIGH;
              tmr  <= HALF_L;
            end
          end else tmr <= tmr - 1'b1;
        end
        default: begin
          if (tmr == '0) begin
            st   <= D_IDLE;
            done <= 1'b1;
          end else tmr <= tmr - 1'b1;
        end
      endcase
    end
  end

  a_r2_hold_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pClk) |-> $stable(pDat));

  a_r2_change_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    (pOe && !$stable(pDat)) |-> $rose(pClk));

  a_r10_clock_parked: assert property (@(posedge clk) disable iff (!rstN)
    (st == D_IDLE || st == D_WAIT) |-> !pClk);
endmodule

// File: rtl/prog_host_ctl.sv
`timescale 1ns/1ps
module prog_host_ctl
  import prog_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [WORD_W-1:0] reqWord,
  output logic              reqReady,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspWord,
  output logic              verifyErr,
  output logic [ADDR_W-1:0] errAddr,
  output logic              modeEn,
  output strobeT            stb,
  input  logic              done,
  input  logic [WORD_W-1:0] rxWord
);
  typedef enum logic [2:0] {C_IDLE, C_CMDW, C_GAP1W, C_DATW, C_GAP2W, C_HALT} cstE;

  cstE               st;
  opE                curCmd;
  opE                launchCmd;
  logic              launch;
  logic              seqMode;
  logic              preInc;
  logic              isProg;
  logic [WORD_W-1:0] wordR;
  logic [ADDR_W-1:0] addrR;

  assign reqReady = (st == C_IDLE);
  assign isProg   = (reqOp[2:1] == 2'b11);

  always_comb begin
    launch    = 1'b0;
    launchCmd = OP_LOAD;
    if (st == C_IDLE && reqValid) begin
      launch = 1'b1;
      if (isProg) launchCmd = (addrR == '1) ? OP_INC : OP_LOAD;
      else        launchCmd = opE'(reqOp);
    end else if (st == C_GAP2W && done && seqMode) begin
      case (curCmd)
        OP_INC:   if (preInc) begin launch = 1'b1; launchCmd = OP_LOAD; end
        OP_LOAD:  begin launch = 1'b1; launchCmd = OP_BEGIN; end
        OP_BEGIN: begin launch = 1'b1; launchCmd = OP_END;   end
        OP_END:   begin launch = 1'b1; launchCmd = OP_READ;  end
        OP_READ:  begin launch = 1'b1; launchCmd = OP_INC;   end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= C_IDLE; curCmd <= OP_LOAD; seqMode <= 1'b0; preInc <= 1'b0;
      wordR <= '0; addrR <= '1; rspValid <= 1'b0; rspWord <= '0;
      verifyErr <= 1'b0; errAddr <= '0; modeEn <= 1'b0; stb <= '0;
    end else begin
      modeEn   <= 1'b1;
      rspValid <= 1'b0;
      stb      <= '0;
      if (st == C_IDLE && reqValid) begin
        wordR   <= reqWord;
        seqMode <= isProg;
        preInc  <= isProg && (addrR == '1);
      end
      if (launch) begin
        st          <= C_CMDW;
        curCmd      <= launchCmd;
        stb.goShift <= 1'b1;
        stb.drive   <= 1'b1;
        stb.pattern <= {(XFER_W-CMD_W)'(0), cmdOf(launchCmd)};
        if (st == C_GAP2W && launchCmd == OP_LOAD) preInc <= 1'b0;
      end else begin
        case (st)
          C_CMDW: if (done) begin
            stb.goWait <= 1'b1;
            if (curCmd == OP_INC) addrR <= addrR + 1'b1;
            if (curCmd == OP_LOAD || curCmd == OP_READ) st <= C_GAP1W;
            else begin
              stb.longWait <= (curCmd == OP_END);
              st <= C_GAP2W;
            end
          end
          C_GAP1W: if (done) begin
            stb.goShift   <= 1'b1;
            stb.dataPhase <= 1'b1;
            stb.drive     <= (curCmd == OP_LOAD);
            stb.pattern   <= (curCmd == OP_LOAD) ?
                             {1'b0, (FIELD_W-WORD_W)'(0), wordR, 1'b0} : '0;
            st <= C_DATW;
          end
          C_DATW: if (done) begin
            if (curCmd == OP_READ) rspWord <= rxWord;
            if (curCmd == OP_READ && seqMode && rxWord != wordR) begin
              verifyErr <= 1'b1;
              errAddr   <= addrR;
              st        <= C_HALT;
            end else begin
              stb.goWait <= 1'b1;
              st <= C_GAP2W;
            end
          end
          C_GAP2W: if (done) begin
            st       <= C_IDLE;
            rspValid <= 1'b1;
            seqMode  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r7_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    verifyErr |=> (verifyErr && !reqReady && $stable(errAddr)));

  a_r9_link_quiet: assert property (@(posedge clk) disable iff (!rstN)
    verifyErr |-> !stb.goShift);

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrR) |-> (addrR == $past(addrR) + 1'b1));
endmodule

// File: rtl/prog_link_host.sv
`timescale 1ns/1ps
module prog_link_host
  import prog_host_pkg::*;
#(
  parameter int CLK_MHZ  = 200,
  parameter int SETUP_NS = 100,
  parameter int SHORT_US = 1,
  parameter int LONG_US  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [WORD_W-1:0] reqWord,
  output logic              reqReady,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspWord,
  output logic              verifyErr,
  output logic [ADDR_W-1:0] errAddr,
  output logic              modeEn,
  output logic              progClk,
  output logic              progDat,
  output logic              progDatOe,
  input  logic              progDatIn
);
  localparam int HALF_CYC  = (SETUP_NS * CLK_MHZ + 999) / 1000;
  localparam int SHORT_CYC = SHORT_US * CLK_MHZ;
  localparam int LONG_CYC  = LONG_US * CLK_MHZ;

  strobeT            stb;
  logic              done;
  logic [WORD_W-1:0] rxWord;

  prog_host_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqWord(reqWord),
    .reqReady(reqReady), .rspValid(rspValid), .rspWord(rspWord),
    .verifyErr(verifyErr), .errAddr(errAddr), .modeEn(modeEn),
    .stb(stb), .done(done), .rxWord(rxWord)
  );

  prog_host_dp #(.HALF_CYC(HALF_CYC), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .datIn(progDatIn), .done(done),
    .rxWord(rxWord), .pClk(progClk), .pDat(progDat), .pOe(progDatOe)
  );
endmodule

// File: tb/prog_link_host_test.sv
`timescale 1ns/1ps
module prog_link_host_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [11:0] reqWord = '0;
  logic        reqReady, rspValid, verifyErr, modeEn, progClk, progDat, progDatOe;
  logic [11:0] rspWord;
  logic [10:0] errAddr;
  logic        tgtDat = 1'b0;

  always #2.5 clk = ~clk;

  prog_link_host uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqWord(reqWord),
    .reqReady(reqReady), .rspValid(rspValid), .rspWord(rspWord), .verifyErr(verifyErr),
    .errAddr(errAddr), .modeEn(modeEn), .progClk(progClk), .progDat(progDat),
    .progDatOe(progDatOe), .progDatIn(tgtDat)
  );

  int nChk = 0, nBad = 0;
  int shViol = 0, gapDatViol = 0, gapCmdViol = 0, oeViol = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- scoreboard queue -----------------
  typedef struct { logic [5:0] cmd; logic [15:0] pat; bit hasPat; } expT;
  expT expQ[$];

  function automatic void pushCmd(input logic [5:0] c);
    expT e; e.cmd = c; e.pat = '0; e.hasPat = 0; expQ.push_back(e);
  endfunction
  function automatic void pushLoad(input logic [11:0] w);
    expT e; e.cmd = 6'h02; e.pat = {1'b0, 2'b00, w, 1'b0}; e.hasPat = 1; expQ.push_back(e);
  endfunction

  // ---------------- target model -----------------
  logic [11:0] mem [int];
  logic [10:0] tgtAddr = 11'h7FF;
  logic [11:0] tgtBuf = '0;
  int          corruptAddr = -1;
  logic [10:0] bAddr = 11'h7FF;
  bit          hasPrev = 0, prevWasEnd = 0;
  realtime     prevEnd = 0.0;

  function automatic logic [11:0] memRd(input int a);
    return mem.exists(a) ? mem[a] : 12'hFFF;
  endfunction

  realtime lastFall = -1000.0, lastChg = -1000.0;
  always @(negedge progClk) begin
    lastFall = $realtime;
    if (progDatOe && ($realtime - lastChg) < 100.0) shViol++;
  end
  always @(progDat) if (progDatOe) begin
    if (($realtime - lastFall) < 100.0) shViol++;
    lastChg = $realtime;
  end

  initial begin : target
    forever begin
      logic [5:0]  cmd;
      logic [15:0] d;
      logic [13:0] rdField;
      realtime     tR, tF;
      expT         e;
      cmd = '0; d = '0; tF = 0.0;
      for (int k = 0; k < 6; k++) begin
        @(posedge progClk); tR = $realtime;
        if (k == 0 && hasPrev && (tR - prevEnd) < (prevWasEnd ? 100000.0 : 1000.0)) gapCmdViol++;
        @(negedge progClk); tF = $realtime; #1; cmd[k] = progDat;
      end
      if (cmd == 6'h02 || cmd == 6'h04) begin
        rdField = {2'b11, memRd(int'(tgtAddr))};
        for (int k = 0; k < 16; k++) begin
          @(posedge progClk);
          if (k == 0 && ($realtime - tF) < 1000.0) gapDatViol++;
          if (cmd == 6'h04) begin #1; tgtDat = (k >= 1 && k <= 14) ? rdField[k-1] : 1'b0; end
          @(negedge progClk); tF = $realtime; #1; d[k] = progDat;
          if (cmd == 6'h04 && progDatOe) oeViol++;
          if (cmd == 6'h02 && !progDatOe) oeViol++;
        end
        tgtDat = 1'b0;
      end
      case (cmd)
        6'h02: tgtBuf = d[12:1];
        6'h06: tgtAddr = tgtAddr + 1'b1;
        6'h08: mem[int'(tgtAddr)] = (int'(tgtAddr) == corruptAddr) ? (tgtBuf ^ 12'h004) : tgtBuf;
        6'h09: mem.delete();
        default: ;
      endcase
      // monitor: pop and compare
      if (expQ.size() == 0) chk(0, "R1 unexpected command", 32'(cmd), 0);
      else begin
        e = expQ.pop_front();
        chk(cmd == e.cmd, "R1 command code/order", 32'(cmd), 32'(e.cmd));
        if (e.hasPat) chk(d == e.pat, "R3 load transfer field", 32'(d), 32'(e.pat));
      end
      prevEnd = tF; prevWasEnd = (cmd == 6'h0E); hasPrev = 1;
    end
  end

  // ---------------- driver -----------------
  task automatic doReq(input logic [2:0] op, input logic [11:0] w, output logic [11:0] rsp);
    case (op)
      3'd0: pushLoad(w);
      3'd1: pushCmd(6'h04);
      3'd2: begin pushCmd(6'h06); bAddr = bAddr + 1'b1; end
      3'd3: pushCmd(6'h08);
      3'd4: pushCmd(6'h0E);
      3'd5: pushCmd(6'h09);
      default: begin
        if (bAddr == 11'h7FF) begin pushCmd(6'h06); bAddr = '0; end
        pushLoad(w); pushCmd(6'h08); pushCmd(6'h0E); pushCmd(6'h04);
        if (int'(bAddr) != corruptAddr) begin pushCmd(6'h06); bAddr = bAddr + 1'b1; end
      end
    endcase
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqOp = op; reqWord = w; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R7 ready drops after accept", 32'(reqReady), 0);
    while (!(rspValid || verifyErr)) @(negedge clk);
    rsp = rspWord;
    if (rspValid) begin
      @(negedge clk);
      chk(rspValid == 1'b0, "R7 rspValid single cycle", 32'(rspValid), 0);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    tgtAddr = 11'h7FF; bAddr = 11'h7FF; hasPrev = 0;
    rstN = 1'b1;
  endtask

  // ---------------- watchdog -----------------
  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired (R7 completion) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  // ---------------- scenarios -----------------
  initial begin
    logic [11:0] r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 ready after reset", 32'(reqReady), 1);
    chk(modeEn == 1'b1, "R10 mode enable after reset", 32'(modeEn), 1);
    chk(progClk == 1'b0, "R10 link clock low", 32'(progClk), 0);
    chk(verifyErr == 1'b0, "R10 no error after reset", 32'(verifyErr), 0);

    // primitive commands
    doReq(3'd5, '0, r);                     // erase
    doReq(3'd2, '0, r);                     // 0x7FF -> 0
    doReq(3'd1, '0, r);
    chk(r == 12'hFFF, "R4 read of erased word (top field bits ignored)", 32'(r), 32'hFFF);
    doReq(3'd0, 12'hABC, r);
    doReq(3'd3, '0, r);
    doReq(3'd4, '0, r);
    doReq(3'd1, '0, r);
    chk(r == 12'hABC, "R4 read back written word", 32'(r), 32'hABC);
    chk(memRd(0) == 12'hABC, "R3 target stored loaded word", 32'(memRd(0)), 32'hABC);

    // program-and-verify after mode re-entry
    doReset();
    doReq(3'd6, 12'h123, r);
    chk(r == 12'h123, "R8 verify word returned", 32'(r), 32'h123);
    chk(memRd(0) == 12'h123, "R8 first word at address 0 after extra increment", 32'(memRd(0)), 32'h123);
    doReq(3'd7, 12'h5A5, r);
    chk(memRd(1) == 12'h5A5, "R8 second word at address 1", 32'(memRd(1)), 32'h5A5);
    chk(tgtAddr == 11'd2, "R8 target address after two passes", 32'(tgtAddr), 2);
    chk(verifyErr == 1'b0, "R9 no error on matching verify", 32'(verifyErr), 0);

    // verify failure
    corruptAddr = 2;
    doReq(3'd6, 12'h0F0, r);
    chk(verifyErr == 1'b1, "R9 error raised on mismatch", 32'(verifyErr), 1);
    chk(errAddr == 11'd2, "R9 failing address held", 32'(errAddr), 2);
    repeat (2000) @(negedge clk);
    chk(verifyErr == 1'b1 && reqReady == 1'b0, "R9 halted and sticky", 32'({verifyErr, reqReady}), 32'b10);
    chk(tgtAddr == 11'd2, "R9 no increment after mismatch", 32'(tgtAddr), 2);
    chk(expQ.size() == 0, "R8 all expected commands observed", 32'(expQ.size()), 0);

    chk(shViol == 0, "R2 setup/hold around falling edge", 32'(shViol), 0);
    chk(gapDatViol == 0, "R5 command-to-data gap", 32'(gapDatViol), 0);
    chk(gapCmdViol == 0, "R6 inter-command gap", 32'(gapCmdViol), 0);
    chk(oeViol == 0, "R4 output enable during transfers", 32'(oeViol), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule